// File: doc/BRIEF.md
# NAND Flash PIO Command Sequencer

This block runs one programmed-I/O transaction on an 8-bit NAND flash bus each time the host sets the start bit of its control word. The host first presents two command opcodes, a 32-bit low address word, an 8-bit high address byte and, for writes, a 32-bit data register value. It then writes the control word. The block captures the opcodes, the address and the control word at that start write. It then drives the chip enable, command latch, address latch, write strobe, read strobe and I/O bus through up to four phases: first command, address bytes, second command and data bytes. The start bit reads back as `busy` until the last enabled phase ends, and the host polls it for completion.

A single control word picks the phases and their order. The second command can come before the data phase (page read, random data out) or after it (page program). A status read is a lone command followed by a one-byte receive. An ID read is a command, one address byte and a four-byte receive. Strobe timing comes from small cycle counters set by the timing inputs. The data register is a plain register: there is no stream handshake. Received bytes land in it, and it is read back on `data_q`.

Top module: `nand_pio_seq`

## Requirements
- R1: After reset `busy` is 0, `data_q` is 0, `nand_ce_n`, `nand_we_n` and `nand_re_n` are 1, and `nand_cle`, `nand_ale` and `nand_io_oe` are 0.
- R2: Control word bits: 0 start, 1 first-command enable, 2 address enable, 3 data enable, 4 receive (1) or send (0), 5 second-command enable, 6 data-before-second-command, 7 chip enable, 11:8 address byte count, 13:12 data byte count minus one.
  - A write with bit 0 set, made while idle, raises `busy` on the next cycle.
  - `busy` then stays high for exactly the sum, over every byte of every enabled phase, of setup + low + high cycles, with no idle cycles between bytes.
  - A disabled phase takes no cycles.
  - A start with no phase enabled leaves `busy` low.
- R3: With bit 6 clear, the bus order is first command, address bytes, second command, data bytes.
- R4: With bit 6 set, the bus order is first command, address bytes, data bytes, second command.
- R5: The address phase runs as many bytes as the count field gives, with 6 to 15 treated as 5 and 0 skipping the phase.
  - Bytes go out from bit 7:0 of the low address word upward, and the fifth byte is the high address byte.
  - `nand_ale` is high during address bytes and `nand_cle` during command bytes, never both together.
- R6: Send data goes out little-endian: byte n is `data_q[8n+7:8n]`, for size field + 1 bytes.
  - The I/O bus holds steady while the write strobe is low.
- R7: Receive data is taken on the clock edge that ends the read strobe's low time, into `data_q[8n+7:8n]` for byte n. Bytes beyond the size are left unchanged.
- R8: Every byte takes `tim_setup` cycles with strobes high, then the strobe low for `tim_we_lo` (send) or `tim_re_lo` (receive) cycles, then high for `tim_we_hi` or `tim_re_hi` cycles.
  - A timing value of 0 acts as 1.
  - The write and read strobes are never low together.
- R9: A control write while `busy` is ignored. A data register write while `busy` is ignored.
- R10: `nand_ce_n` is low exactly while `busy` is high with bit 7 set, and high otherwise.
- R11: `nand_io_oe` is high only during command, address and send-data bytes. It is low during receive bytes and while idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ctrl_we | input | 1 | Control word write strobe |
| ctrl_wdata | input | 14 | Control word (fields in R2) |
| cmd1_i | input | 8 | First command opcode |
| cmd2_i | input | 8 | Second command opcode |
| addr_lo_i | input | 32 | Address bytes 0 to 3 |
| addr_hi_i | input | 8 | Address byte 4 |
| data_we | input | 1 | Data register write strobe |
| data_wdata | input | 32 | Data register write value |
| tim_setup | input | 4 | Setup cycles before each strobe |
| tim_we_lo | input | 4 | Write strobe low cycles |
| tim_we_hi | input | 4 | Write strobe high cycles |
| tim_re_lo | input | 4 | Read strobe low cycles |
| tim_re_hi | input | 4 | Read strobe high cycles |
| busy | output | 1 | Start bit readback, high while running |
| data_q | output | 32 | Data register |
| nand_ce_n | output | 1 | Chip enable, active low |
| nand_cle | output | 1 | Command latch enable |
| nand_ale | output | 1 | Address latch enable |
| nand_we_n | output | 1 | Write strobe, active low |
| nand_re_n | output | 1 | Read strobe, active low |
| nand_io_out | output | 8 | I/O bus output value |
| nand_io_oe | output | 1 | I/O bus output enable |
| nand_io_in | input | 8 | I/O bus input value |

## Verification
The properties assume that the timing inputs do not change while a transaction runs, because the strobe widths are read from them live. They also assume that the flash model changes `nand_io_in` only after the read strobe has fallen. The stimulus sets the timing inputs only while `busy` is low. It drives the read bytes on the falling clock edge that follows each read strobe fall, so every byte is settled before its capture edge. Writes made during a transaction are aimed at cycles where the read strobe is high, so that an ignored data write can be told apart from a received byte.

// File: rtl/nand_pio_pkg.sv
package nand_pio_pkg;

  localparam int CTRL_W = 14;

  typedef enum logic [2:0] {
    PH_IDLE,
    PH_CMD1,
    PH_ADDR,
    PH_CMD2,
    PH_DATA
  } phase_e;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_SETUP,
    ST_LOW,
    ST_HIGH
  } stage_e;

  typedef struct packed {
    logic [1:0] size_m1;
    logic [3:0] addr_cnt;
    logic       ce;
    logic       data_first;
    logic       cmd2_en;
    logic       rx;
    logic       data_en;
    logic       addr_en;
    logic       cmd1_en;
    logic       go;
  } ctrl_t;

endpackage

// File: rtl/nand_phase_plan.sv
module nand_phase_plan
  import nand_pio_pkg::*;
(
  input  phase_e cur,
  input  ctrl_t  ctrl,
  output phase_e nxt
);

  phase_e ord [4];
  logic   en  [4];
  logic   passed;

  function automatic logic phase_on(phase_e p, ctrl_t c);
    case (p)
      PH_CMD1: phase_on = c.cmd1_en;
      PH_ADDR: phase_on = c.addr_en && (c.addr_cnt != 4'd0);
      PH_CMD2: phase_on = c.cmd2_en;
      PH_DATA: phase_on = c.data_en;
      default: phase_on = 1'b0;
    endcase
  endfunction

  always_comb begin
    ord[0] = PH_CMD1;
    ord[1] = PH_ADDR;
    ord[2] = ctrl.data_first ? PH_DATA : PH_CMD2;
    ord[3] = ctrl.data_first ? PH_CMD2 : PH_DATA;
    for (int i = 0; i < 4; i++) en[i] = phase_on(ord[i], ctrl);
  end

  always_comb begin
    passed = (cur == PH_IDLE);
    nxt    = PH_IDLE;
    for (int i = 0; i < 4; i++) begin
      if (passed && (nxt == PH_IDLE) && en[i]) nxt = ord[i];
      if (ord[i] == cur) passed = 1'b1;
    end
  end

endmodule

// File: rtl/nand_byte_timer.sv
module nand_byte_timer
  import nand_pio_pkg::*;
#(
  parameter int TW = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic [TW-1:0] t_setup,
  input  logic [TW-1:0] t_low,
  input  logic [TW-1:0] t_high,
  output stage_e        stage,
  output logic          low_last,
  output logic          done
);

  logic [TW-1:0] cnt_q;
  logic [TW-1:0] lim;
  logic          at_lim;

  function automatic logic [TW-1:0] last_of(logic [TW-1:0] t);
    last_of = (t == '0) ? '0 : t - 1'b1;
  endfunction

  always_comb begin
    case (stage)
      ST_SETUP: lim = last_of(t_setup);
      ST_LOW:   lim = last_of(t_low);
      ST_HIGH:  lim = last_of(t_high);
      default:  lim = '0;
    endcase
  end

  assign at_lim   = (cnt_q == lim);
  assign low_last = (stage == ST_LOW) && at_lim;
  assign done     = (stage == ST_HIGH) && at_lim;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage <= ST_IDLE;
      cnt_q <= '0;
    end else if (start) begin
      stage <= ST_SETUP;
      cnt_q <= '0;
    end else begin
      case (stage)
        ST_SETUP: if (at_lim) begin stage <= ST_LOW;  cnt_q <= '0; end
                  else cnt_q <= cnt_q + 1'b1;
        ST_LOW:   if (at_lim) begin stage <= ST_HIGH; cnt_q <= '0; end
                  else cnt_q <= cnt_q + 1'b1;
        ST_HIGH:  if (at_lim) begin stage <= ST_IDLE; cnt_q <= '0; end
                  else cnt_q <= cnt_q + 1'b1;
        default:  cnt_q <= '0;
      endcase
    end
  end

endmodule

// File: rtl/nand_pio_seq.sv
module nand_pio_seq
  import nand_pio_pkg::*;
#(
  parameter int DATA_BYTES = 4,
  parameter int ADDR_MAX   = 5,
  parameter int TW         = 4
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      ctrl_we,
  input  logic [CTRL_W-1:0]         ctrl_wdata,
  input  logic [7:0]                cmd1_i,
  input  logic [7:0]                cmd2_i,
  input  logic [31:0]               addr_lo_i,
  input  logic [8*(ADDR_MAX-4)-1:0] addr_hi_i,
  input  logic                      data_we,
  input  logic [8*DATA_BYTES-1:0]   data_wdata,
  input  logic [TW-1:0]             tim_setup,
  input  logic [TW-1:0]             tim_we_lo,
  input  logic [TW-1:0]             tim_we_hi,
  input  logic [TW-1:0]             tim_re_lo,
  input  logic [TW-1:0]             tim_re_hi,
  output logic                      busy,
  output logic [8*DATA_BYTES-1:0]   data_q,
  output logic                      nand_ce_n,
  output logic                      nand_cle,
  output logic                      nand_ale,
  output logic                      nand_we_n,
  output logic                      nand_re_n,
  output logic [7:0]                nand_io_out,
  output logic                      nand_io_oe,
  input  logic [7:0]                nand_io_in
);

  localparam int DWID   = 8 * DATA_BYTES;
  localparam int AWID   = 8 * ADDR_MAX;
  localparam int SIZEW  = $clog2(DATA_BYTES);
  localparam int BIDXW  = $clog2((ADDR_MAX > DATA_BYTES) ? ADDR_MAX : DATA_BYTES);
  localparam int NSLOT  = 1 << BIDXW;

  ctrl_t             ctrl_q;
  ctrl_t             ctrl_new;
  phase_e            phase_q;
  phase_e            first_ph;
  phase_e            next_ph;
  logic [7:0]        cmd1_q;
  logic [7:0]        cmd2_q;
  logic [AWID-1:0]   addr_q;
  logic [BIDXW-1:0]  bidx_q;
  logic [BIDXW-1:0]  last_idx;
  logic [3:0]        acnt_eff;
  logic [7:0]        abyte [NSLOT];
  logic [7:0]        dbyte [DATA_BYTES];
  logic              go_req;
  logic              is_read;
  logic              last_byte;
  logic              tmr_start;
  logic              tmr_done;
  logic              tmr_low_last;
  stage_e            tmr_stage;
  logic [TW-1:0]     t_low;
  logic [TW-1:0]     t_high;

  assign ctrl_new = ctrl_t'(ctrl_wdata);
  assign busy     = ctrl_q.go;
  assign go_req   = ctrl_we && ctrl_new.go && !busy;

  nand_phase_plan u_first (
    .cur  (PH_IDLE),
    .ctrl (ctrl_new),
    .nxt  (first_ph)
  );

  nand_phase_plan u_next (
    .cur  (phase_q),
    .ctrl (ctrl_q),
    .nxt  (next_ph)
  );

  assign is_read = (phase_q == PH_DATA) && ctrl_q.rx;
  assign t_low   = is_read ? tim_re_lo : tim_we_lo;
  assign t_high  = is_read ? tim_re_hi : tim_we_hi;

  assign acnt_eff = (ctrl_q.addr_cnt > 4'(ADDR_MAX)) ? 4'(ADDR_MAX) : ctrl_q.addr_cnt;

  always_comb begin
    case (phase_q)
      PH_ADDR: last_idx = BIDXW'(acnt_eff - 4'd1);
      PH_DATA: last_idx = BIDXW'(ctrl_q.size_m1);
      default: last_idx = '0;
    endcase
  end

  assign last_byte = (bidx_q == last_idx);
  assign tmr_start = (go_req && (first_ph != PH_IDLE)) ||
                     (tmr_done && !(last_byte && (next_ph == PH_IDLE)));

  nand_byte_timer #(.TW(TW)) u_timer (
    .clk      (clk),
    .rst_n    (rst_n),
    .start    (tmr_start),
    .t_setup  (tim_setup),
    .t_low    (t_low),
    .t_high   (t_high),
    .stage    (tmr_stage),
    .low_last (tmr_low_last),
    .done     (tmr_done)
  );

  // Sequencing state: captured at start, advanced at each byte end.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q  <= '0;
      phase_q <= PH_IDLE;
      bidx_q  <= '0;
      cmd1_q  <= '0;
      cmd2_q  <= '0;
      addr_q  <= '0;
    end else if (go_req) begin
      ctrl_q    <= ctrl_new;
      ctrl_q.go <= (first_ph != PH_IDLE);
      phase_q   <= first_ph;
      bidx_q    <= '0;
      cmd1_q    <= cmd1_i;
      cmd2_q    <= cmd2_i;
      addr_q    <= {addr_hi_i, addr_lo_i};
    end else if (tmr_done) begin
      if (!last_byte) begin
        bidx_q <= bidx_q + 1'b1;
      end else begin
        bidx_q  <= '0;
        phase_q <= next_ph;
        if (next_ph == PH_IDLE) ctrl_q.go <= 1'b0;
      end
    end
  end

  // Address byte slots; slots past ADDR_MAX read as zero.
  for (genvar g = 0; g < NSLOT; g++) begin : g_abyte
    if (g < ADDR_MAX) begin : g_live
      assign abyte[g] = addr_q[8*g +: 8];
    end else begin : g_pad
      assign abyte[g] = 8'h00;
    end
  end

  // Data register, one byte lane per generate step.
  for (genvar g = 0; g < DATA_BYTES; g++) begin : g_dlane
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        dbyte[g] <= 8'h00;
      end else if (data_we && !busy) begin
        dbyte[g] <= data_wdata[8*g +: 8];
      end else if (tmr_low_last && is_read && (bidx_q[SIZEW-1:0] == SIZEW'(g))) begin
        dbyte[g] <= nand_io_in;
      end
    end
    assign data_q[8*g +: 8] = dbyte[g];
  end

  always_comb begin
    case (phase_q)
      PH_CMD1: nand_io_out = cmd1_q;
      PH_CMD2: nand_io_out = cmd2_q;
      PH_ADDR: nand_io_out = abyte[bidx_q];
      PH_DATA: nand_io_out = ctrl_q.rx ? 8'h00 : dbyte[bidx_q[SIZEW-1:0]];
      default: nand_io_out = 8'h00;
    endcase
  end

  assign nand_cle   = busy && ((phase_q == PH_CMD1) || (phase_q == PH_CMD2));
  assign nand_ale   = busy && (phase_q == PH_ADDR);
  assign nand_we_n  = !((tmr_stage == ST_LOW) && !is_read);
  assign nand_re_n  = !((tmr_stage == ST_LOW) && is_read);
  assign nand_io_oe = busy && !is_read;
  assign nand_ce_n  = !(busy && ctrl_q.ce);

endmodule

// File: rtl/nand_pio_seq_chk.sv
module nand_pio_seq_chk #(
  parameter int DW = 32
) (
  input logic          clk,
  input logic          rst_n,
  input logic          busy,
  input logic          data_we,
  input logic [DW-1:0] data_q,
  input logic          nand_ce_n,
  input logic          nand_cle,
  input logic          nand_ale,
  input logic          nand_we_n,
  input logic          nand_re_n,
  input logic [7:0]    nand_io_out,
  input logic          nand_io_oe
);

  p_idle_quiet_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (nand_we_n && nand_re_n && !nand_cle && !nand_ale && !nand_io_oe));

  p_latch_excl_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !(nand_cle && nand_ale));

  p_io_steady_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (!nand_we_n && $past(!nand_we_n)) |-> $stable(nand_io_out));

  p_strobe_excl_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !(!nand_we_n && !nand_re_n));

  p_data_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && data_we && nand_re_n) |=> $stable(data_q));

  p_ce_idle_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> nand_ce_n);

  p_no_drive_on_read_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !nand_re_n |-> !nand_io_oe);

endmodule

bind nand_pio_seq nand_pio_seq_chk #(.DW(DWID)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .busy        (busy),
  .data_we     (data_we),
  .data_q      (data_q),
  .nand_ce_n   (nand_ce_n),
  .nand_cle    (nand_cle),
  .nand_ale    (nand_ale),
  .nand_we_n   (nand_we_n),
  .nand_re_n   (nand_re_n),
  .nand_io_out (nand_io_out),
  .nand_io_oe  (nand_io_oe)
);

// File: tb/nand_pio_seq_bench.sv
module nand_pio_seq_bench;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        ctrl_we;
  logic [13:0] ctrl_wdata;
  logic [7:0]  cmd1_i, cmd2_i;
  logic [31:0] addr_lo_i;
  logic [7:0]  addr_hi_i;
  logic        data_we;
  logic [31:0] data_wdata;
  logic [3:0]  tim_setup, tim_we_lo, tim_we_hi, tim_re_lo, tim_re_hi;
  logic        busy;
  logic [31:0] data_q;
  logic        nand_ce_n, nand_cle, nand_ale, nand_we_n, nand_re_n, nand_io_oe;
  logic [7:0]  nand_io_out;
  logic [7:0]  nand_io_in;

  always #4 clk = ~clk;

  nand_pio_seq u_nand_pio_seq (
    .clk(clk), .rst_n(rst_n), .ctrl_we(ctrl_we), .ctrl_wdata(ctrl_wdata),
    .cmd1_i(cmd1_i), .cmd2_i(cmd2_i), .addr_lo_i(addr_lo_i), .addr_hi_i(addr_hi_i),
    .data_we(data_we), .data_wdata(data_wdata),
    .tim_setup(tim_setup), .tim_we_lo(tim_we_lo), .tim_we_hi(tim_we_hi),
    .tim_re_lo(tim_re_lo), .tim_re_hi(tim_re_hi),
    .busy(busy), .data_q(data_q), .nand_ce_n(nand_ce_n), .nand_cle(nand_cle),
    .nand_ale(nand_ale), .nand_we_n(nand_we_n), .nand_re_n(nand_re_n),
    .nand_io_out(nand_io_out), .nand_io_oe(nand_io_oe), .nand_io_in(nand_io_in)
  );

  // Event codes: 1xx command byte, 2xx address byte, 3xx sent data byte, 000 read strobe.
  localparam int NV = 8;
  localparam logic [13:0] V_CTRL [NV] = '{14'h009B, 14'h319F, 14'h05A7, 14'h35EF,
                                          14'h03A7, 14'h12BF, 14'h2089, 14'h0707};
  localparam logic [7:0]  V_C1 [NV] = '{8'h70, 8'h90, 8'h00, 8'h80, 8'h60, 8'h05, 8'h00, 8'hFF};
  localparam logic [7:0]  V_C2 [NV] = '{8'h00, 8'h00, 8'h30, 8'h10, 8'hD0, 8'hE0, 8'h00, 8'h00};
  localparam logic [31:0] V_A1 [NV] = '{32'h0, 32'h0, 32'h12345678, 32'h00020100,
                                        32'h00ABCDEF, 32'h00000804, 32'h0, 32'hDEADBEEF};
  localparam logic [7:0]  V_A2 [NV] = '{8'h00, 8'h00, 8'h9A, 8'h01, 8'h00, 8'h00, 8'h00, 8'h77};
  localparam logic [31:0] V_TX [NV] = '{32'h11223344, 32'h0, 32'h55667788, 32'hDDCCBBAA,
                                        32'h0BADF00D, 32'hCAFE1234, 32'h00665544, 32'h01020304};
  localparam logic [31:0] V_DX [NV] = '{32'h112233A0, 32'hA3A2A1A0, 32'h55667788, 32'hDDCCBBAA,
                                        32'h0BADF00D, 32'hCAFEA1A0, 32'h00665544, 32'h01020304};
  localparam int V_N   [NV] = '{2, 6, 7, 11, 5, 6, 3, 6};
  localparam int V_CYC [NV] = '{13, 40, 42, 66, 30, 38, 18, 36};
  localparam logic [9:0] V_EV [NV][12] = '{
    '{10'h170, 10'h000, 10'h0, 10'h0, 10'h0, 10'h0, 10'h0, 10'h0, 10'h0, 10'h0, 10'h0, 10'h0},
    '{10'h190, 10'h200, 10'h000, 10'h000, 10'h000, 10'h000, 10'h0, 10'h0, 10'h0, 10'h0, 10'h0, 10'h0},
    '{10'h100, 10'h278, 10'h256, 10'h234, 10'h212, 10'h29A, 10'h130, 10'h0, 10'h0, 10'h0, 10'h0, 10'h0},
    '{10'h180, 10'h200, 10'h201, 10'h202, 10'h200, 10'h201, 10'h3AA, 10'h3BB, 10'h3CC, 10'h3DD, 10'h110, 10'h0},
    '{10'h160, 10'h2EF, 10'h2CD, 10'h2AB, 10'h1D0, 10'h0, 10'h0, 10'h0, 10'h0, 10'h0, 10'h0, 10'h0},
    '{10'h105, 10'h204, 10'h208, 10'h1E0, 10'h000, 10'h000, 10'h0, 10'h0, 10'h0, 10'h0, 10'h0, 10'h0},
    '{10'h344, 10'h355, 10'h366, 10'h0, 10'h0, 10'h0, 10'h0, 10'h0, 10'h0, 10'h0, 10'h0, 10'h0},
    '{10'h1FF, 10'h2EF, 10'h2BE, 10'h2AD, 10'h2DE, 10'h277, 10'h0, 10'h0, 10'h0, 10'h0, 10'h0, 10'h0}
  };

  int n_chk = 0;
  int n_bad = 0;

  // Bus monitor state
  logic [9:0] ev_log [16];
  int  log_n, busy_cyc, rd_cnt, width_err, ce_err, we_run, re_run;
  int  exp_welo, exp_relo;
  logic exp_ce_n;
  logic prev_we = 1'b1, prev_re = 1'b1;

  always @(negedge clk) begin
    if (prev_we && !nand_we_n) begin
      if (log_n < 16) ev_log[log_n] = {nand_cle ? 2'b01 : (nand_ale ? 2'b10 : 2'b11), nand_io_out};
      log_n++;
    end
    if (prev_re && !nand_re_n) begin
      if (log_n < 16) ev_log[log_n] = 10'h000;
      log_n++;
      nand_io_in = 8'hA0 + 8'(rd_cnt);
      rd_cnt++;
    end
    if (!nand_we_n) we_run++;
    else if (!prev_we) begin
      if (we_run != exp_welo) width_err++;
      we_run = 0;
    end
    if (!nand_re_n) re_run++;
    else if (!prev_re) begin
      if (re_run != exp_relo) width_err++;
      re_run = 0;
    end
    if (busy) begin
      busy_cyc++;
      if (nand_ce_n !== exp_ce_n) ce_err++;
    end
    prev_we = nand_we_n;
    prev_re = nand_re_n;
  end

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic clear_mon();
    log_n = 0; busy_cyc = 0; rd_cnt = 0; width_err = 0; ce_err = 0;
  endtask

  task automatic write_data(input logic [31:0] v);
    @(negedge clk); data_we = 1'b1; data_wdata = v;
    @(negedge clk); data_we = 1'b0;
  endtask

  task automatic write_ctrl(input logic [13:0] v);
    @(negedge clk); ctrl_we = 1'b1; ctrl_wdata = v;
    @(negedge clk); ctrl_we = 1'b0;
  endtask

  task automatic wait_idle();
    for (int k = 0; k < 2000 && busy; k++) @(negedge clk);
    @(negedge clk);
  endtask

  task automatic load_vec(input int i);
    cmd1_i = V_C1[i]; cmd2_i = V_C2[i]; addr_lo_i = V_A1[i]; addr_hi_i = V_A2[i];
    exp_ce_n = !V_CTRL[i][7];
  endtask

  task automatic check_events(input string req, input int i);
    logic [31:0] mism;
    mism = 0;
    for (int k = 0; k < V_N[i] && k < 16; k++) if (ev_log[k] !== V_EV[i][k]) mism = mism + 1;
    check({req, " event count"}, 32'(log_n), 32'(V_N[i]));
    check({req, " event mismatches"}, mism, 32'h0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog R2 act=hung exp=idle");
    $display("test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end

  initial begin
    rst_n = 1'b0; ctrl_we = 1'b0; ctrl_wdata = '0; data_we = 1'b0; data_wdata = '0;
    cmd1_i = '0; cmd2_i = '0; addr_lo_i = '0; addr_hi_i = '0; nand_io_in = '0;
    tim_setup = 4'd2; tim_we_lo = 4'd2; tim_we_hi = 4'd2; tim_re_lo = 4'd3; tim_re_hi = 4'd2;
    exp_welo = 2; exp_relo = 3; exp_ce_n = 1'b1; we_run = 0; re_run = 0;
    clear_mon();
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1: reset state
    check("R1 outputs", {busy, nand_ce_n, nand_we_n, nand_re_n, nand_cle, nand_ale, nand_io_oe},
          {1'b0, 1'b1, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0});
    check("R1 data_q", data_q, 32'h0);

    // Table walk: R2 cycles, R3/R4 order, R5 address, R6 send, R7 receive, R8 widths, R10 CE
    for (int i = 0; i < NV; i++) begin
      write_data(V_TX[i]);
      load_vec(i);
      clear_mon();
      write_ctrl(V_CTRL[i]);
      wait_idle();
      check_events("R3 R4 R5 R6 order", i);
      check("R2 busy cycles", 32'(busy_cyc), 32'(V_CYC[i]));
      check("R6 R7 data_q", data_q, V_DX[i]);
      check("R8 strobe widths", 32'(width_err), 32'h0);
      check("R10 chip enable", 32'(ce_err), 32'h0);
    end

    // R9: start and data writes during a running program transaction are ignored
    write_data(V_TX[3]);
    load_vec(3);
    clear_mon();
    write_ctrl(V_CTRL[3]);
    repeat (10) @(negedge clk);
    write_ctrl(14'h0083);
    write_data(32'hFFFFFFFF);
    wait_idle();
    check("R9 busy cycles after ignored start", 32'(busy_cyc), 32'd66);
    check_events("R9 sequence after ignored start", 3);
    check("R9 data_q after ignored write", data_q, 32'hDDCCBBAA);

    // R8: zero timing values act as one
    tim_setup = 4'd0; tim_we_lo = 4'd0; tim_we_hi = 4'd3; exp_welo = 1;
    cmd1_i = 8'hFF; exp_ce_n = 1'b0;
    clear_mon();
    write_ctrl(14'h0083);
    wait_idle();
    check("R8 zero timing busy cycles", 32'(busy_cyc), 32'd5);
    check("R8 zero timing low width", 32'(width_err), 32'h0);
    check("R5 lone command event", {22'h0, ev_log[0]}, 32'h1FF);
    tim_setup = 4'd2; tim_we_lo = 4'd2; tim_we_hi = 4'd2; exp_welo = 2;

    // R2: start with nothing enabled never raises busy
    clear_mon();
    write_ctrl(14'h0081);
    repeat (4) @(negedge clk);
    check("R2 empty start busy cycles", 32'(busy_cyc), 32'h0);
    check("R10 R11 empty start idle pins", {nand_ce_n, nand_io_oe, 30'h0}, {1'b1, 1'b0, 30'h0});

    $display("test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end

endmodule